// File: doc/BRIEF.md
# SIMT Reconvergence Stack Controller

This block steers control flow for one group of threads that share a single program counter. It holds a stack of entries. Each entry carries a rejoin PC, a next PC and a mask of the threads that are running. The top entry is the group's live state: its next PC is the fetch address, and its mask tells the datapath which threads may commit results.

When a branch arrives, the taken mask is first restricted to the threads that are active. If the active threads all go the same way, only the PC changes. If they split, the current entry is parked at the rejoin PC. An entry for the fall-through threads is pushed, and then an entry for the taken threads, so the taken path runs first. When the top entry's next PC lands on its rejoin PC, that entry is discarded and the entry below takes over. If the inner branch rejoins at the same PC as the enclosing path, the enclosing entry is replaced rather than parked. This costs one slot instead of two.

A branch that needs more slots than are free is dropped and raises a flag that stays set until reset. The bottom entry is never discarded.

Top module: `simt_reconv_stack`

## Requirements
- R1: After a synchronous reset, fetch_pc equals RESET_PC, act_mask has every bit set (bit i is thread i) and overflow is 0.
- R2: With adv_valid high and br_valid low, fetch_pc becomes adv_pc one cycle later and act_mask is unchanged, unless adv_pc equals the top entry's rejoin PC above the bottom entry (R12 then applies).
- R3: A branch whose effective taken mask (br_taken AND act_mask) equals act_mask moves fetch_pc to br_target. A branch whose effective taken mask is zero moves fetch_pc to br_fall. In both cases act_mask is unchanged and nothing is pushed.
- R4: A branch whose effective taken mask is neither zero nor equal to act_mask is divergent. One cycle later, fetch_pc is br_target and act_mask is the effective taken mask.
- R5: When the taken path of a divergent branch reaches br_reconv, fetch_pc becomes br_fall one cycle later and act_mask becomes the original mask AND NOT br_taken.
- R6: When the fall-through path then reaches br_reconv, fetch_pc becomes br_reconv and act_mask returns to the mask held before the branch.
- R7: Bits of br_taken for threads whose act_mask bit is 0 have no effect on the outcome of a branch.
- R8: A divergent branch, taken above the bottom entry, whose br_reconv equals the top entry's rejoin PC uses one stack slot. It replaces the top entry, and after both of its paths reach br_reconv, the next stored entry resumes.
- R9: A divergent branch needing more free slots than remain (one for the R8 case, two otherwise; DEPTH counts the live entry) is ignored. fetch_pc and act_mask hold, and overflow goes to 1 and stays 1 until reset.
- R10: When br_valid and adv_valid are high in the same cycle, the branch is applied and adv_pc is ignored.
- R11: At the bottom entry, no PC value causes a pop: act_mask stays all ones and fetch_pc takes the new value.
- R12: A uniform branch (R3) whose destination equals the top entry's rejoin PC, above the bottom entry, pops in that same update. fetch_pc and act_mask then show the entry below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch event this cycle |
| br_taken | input | NTHREADS | Per-thread taken flags, bit i is thread i |
| br_target | input | PC_W | Taken destination |
| br_fall | input | PC_W | Fall-through destination |
| br_reconv | input | PC_W | Rejoin PC of the branch |
| adv_valid | input | 1 | Sequential PC advance this cycle |
| adv_pc | input | PC_W | New PC for the advance |
| fetch_pc | output | PC_W | Registered fetch address of the top entry |
| act_mask | output | NTHREADS | Registered active-thread mask of the top entry |
| overflow | output | 1 | Sticky flag for a dropped divergent branch |

## Verification
Two functions can fall in the same cycle here. A branch can collide with a sequential advance, and a PC update can coincide with the pop that it triggers. The bench drives br_valid and adv_valid in the same cycle with different destinations, and it checks that only the branch destination appears. It also issues a uniform branch whose target is the current rejoin PC, and it checks that the very next fetch_pc and act_mask already belong to the entry below, with no cycle that shows the rejoin PC under a partial mask.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  typedef enum logic [2:0] {
    SOP_HOLD,
    SOP_SETPC,
    SOP_POP,
    SOP_SPLIT,
    SOP_NEST,
    SOP_OVF
  } stk_op_e;
endpackage

// File: rtl/simt_path_split.sv
module simt_path_split #(
  parameter int NTHREADS = 4
) (
  input  logic [NTHREADS-1:0] active,
  input  logic [NTHREADS-1:0] taken_raw,
  output logic [NTHREADS-1:0] tk_mask,
  output logic [NTHREADS-1:0] nt_mask,
  output logic                tk_none,
  output logic                tk_all
);
  for (genvar g = 0; g < NTHREADS; g++) begin : g_lane
    assign tk_mask[g] = active[g] & taken_raw[g];
    assign nt_mask[g] = active[g] & ~taken_raw[g];
  end
  assign tk_none = (tk_mask == '0);
  assign tk_all  = (nt_mask == '0);
endmodule

// File: rtl/simt_op_select.sv
module simt_op_select
  import simt_stack_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic            br_valid,
  input  logic            tk_none,
  input  logic            tk_all,
  input  logic [PC_W-1:0] br_target,
  input  logic [PC_W-1:0] br_fall,
  input  logic [PC_W-1:0] br_reconv,
  input  logic            adv_valid,
  input  logic [PC_W-1:0] adv_pc,
  input  logic [PC_W-1:0] top_rpc,
  input  logic [LW-1:0]   lvl,
  output stk_op_e         op,
  output logic [PC_W-1:0] dest
);
  logic nest;
  int   room;
  int   need;

  always_comb begin
    nest = (lvl != '0) && (br_reconv == top_rpc);
    room = (DEPTH - 1) - int'(lvl);
    need = nest ? 1 : 2;
    op   = SOP_HOLD;
    dest = '0;
    if (br_valid) begin
      if (tk_none) begin
        op   = SOP_SETPC;
        dest = br_fall;
      end else if (tk_all) begin
        op   = SOP_SETPC;
        dest = br_target;
      end else if (room < need) begin
        op = SOP_OVF;
      end else begin
        op = nest ? SOP_NEST : SOP_SPLIT;
      end
    end else if (adv_valid) begin
      op   = SOP_SETPC;
      dest = adv_pc;
    end
    if (op == SOP_SETPC && lvl != '0 && dest == top_rpc) begin
      op = SOP_POP;
    end
  end
endmodule

// File: rtl/simt_entry_store.sv
module simt_entry_store #(
  parameter int EW = 36,
  parameter int AW = 3,
  localparam int SLOTS = 1 << AW
) (
  input  logic          clk,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [EW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [EW-1:0] wd1,
  input  logic [AW-1:0] ra,
  output logic [EW-1:0] rd
);
  logic [EW-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int          NTHREADS = 4,
  parameter int          PC_W     = 16,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_0010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                br_valid,
  input  logic [NTHREADS-1:0] br_taken,
  input  logic [PC_W-1:0]     br_target,
  input  logic [PC_W-1:0]     br_fall,
  input  logic [PC_W-1:0]     br_reconv,
  input  logic                adv_valid,
  input  logic [PC_W-1:0]     adv_pc,
  output logic [PC_W-1:0]     fetch_pc,
  output logic [NTHREADS-1:0] act_mask,
  output logic                overflow
);
  localparam int LW = $clog2(DEPTH);
  localparam int EW = 2 * PC_W + NTHREADS;

  logic [PC_W-1:0]     top_rpc_q, top_npc_q;
  logic [NTHREADS-1:0] top_mask_q;
  logic [LW-1:0]       lvl_q;
  logic                ovf_q;

  logic [NTHREADS-1:0] tk_mask, nt_mask;
  logic                tk_none, tk_all;
  stk_op_e             op;
  logic [PC_W-1:0]     dest;

  logic          we0, we1;
  logic [LW-1:0] wa0, wa1, ra;
  logic [EW-1:0] wd0, wd1, rd;

  simt_path_split #(.NTHREADS(NTHREADS)) u_split (
    .active   (top_mask_q),
    .taken_raw(br_taken),
    .tk_mask  (tk_mask),
    .nt_mask  (nt_mask),
    .tk_none  (tk_none),
    .tk_all   (tk_all)
  );

  simt_op_select #(.PC_W(PC_W), .DEPTH(DEPTH)) u_sel (
    .br_valid (br_valid),
    .tk_none  (tk_none),
    .tk_all   (tk_all),
    .br_target(br_target),
    .br_fall  (br_fall),
    .br_reconv(br_reconv),
    .adv_valid(adv_valid),
    .adv_pc   (adv_pc),
    .top_rpc  (top_rpc_q),
    .lvl      (lvl_q),
    .op       (op),
    .dest     (dest)
  );

  // Parked entries sit below the live top; lvl_q is the next free slot.
  always_comb begin
    we0 = 1'b0;
    we1 = 1'b0;
    wa0 = lvl_q;
    wa1 = lvl_q + LW'(1);
    wd0 = '0;
    wd1 = {br_reconv, br_fall, nt_mask};
    ra  = (lvl_q == '0) ? '0 : lvl_q - LW'(1);
    if (op == SOP_SPLIT) begin
      we0 = 1'b1;
      we1 = 1'b1;
      wd0 = {top_rpc_q, br_reconv, top_mask_q};
    end else if (op == SOP_NEST) begin
      we0 = 1'b1;
      wd0 = {br_reconv, br_fall, nt_mask};
    end
  end

  simt_entry_store #(.EW(EW), .AW(LW)) u_store (
    .clk(clk),
    .we0(we0), .wa0(wa0), .wd0(wd0),
    .we1(we1), .wa1(wa1), .wd1(wd1),
    .ra (ra),  .rd (rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_rpc_q  <= '0;
      top_npc_q  <= RESET_PC[PC_W-1:0];
      top_mask_q <= '1;
      lvl_q      <= '0;
      ovf_q      <= 1'b0;
    end else begin
      case (op)
        SOP_SETPC: top_npc_q <= dest;
        SOP_POP: begin
          {top_rpc_q, top_npc_q, top_mask_q} <= rd;
          lvl_q <= lvl_q - LW'(1);
        end
        SOP_SPLIT: begin
          {top_rpc_q, top_npc_q, top_mask_q} <= {br_reconv, br_target, tk_mask};
          lvl_q <= lvl_q + LW'(2);
        end
        SOP_NEST: begin
          {top_rpc_q, top_npc_q, top_mask_q} <= {br_reconv, br_target, tk_mask};
          lvl_q <= lvl_q + LW'(1);
        end
        SOP_OVF: ovf_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign fetch_pc = top_npc_q;
  assign act_mask = top_mask_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/simt_reconv_chk.sv
module simt_reconv_chk #(
  parameter int          NTHREADS = 4,
  parameter int          PC_W     = 16,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_0010,
  localparam int         LW       = $clog2(DEPTH)
) (
  input logic                clk,
  input logic                rst,
  input logic                br_valid,
  input logic [NTHREADS-1:0] br_taken,
  input logic [PC_W-1:0]     br_target,
  input logic                adv_valid,
  input logic [PC_W-1:0]     adv_pc,
  input logic [PC_W-1:0]     fetch_pc,
  input logic [NTHREADS-1:0] act_mask,
  input logic                overflow,
  input logic [LW-1:0]       depth
);
  logic [NTHREADS-1:0] eff_tk;
  logic                split_fits;
  assign eff_tk     = br_taken & act_mask;
  assign split_fits = int'(depth) <= DEPTH - 3;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetch_pc == RESET_PC[PC_W-1:0] && act_mask == '1 && !overflow));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r9_dropped_branch: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> ($stable(fetch_pc) && $stable(act_mask)));

  a_r11_base_full_mask: assert property (@(posedge clk) disable iff (rst)
    (depth == '0) |-> (act_mask == '1));

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (adv_valid && !br_valid && depth == '0) |=>
      (fetch_pc == $past(adv_pc) && act_mask == $past(act_mask)));

  a_r4_split_entry: assert property (@(posedge clk) disable iff (rst)
    (br_valid && eff_tk != '0 && eff_tk != act_mask && split_fits) |=>
      (fetch_pc == $past(br_target) && act_mask == $past(eff_tk)));

  a_r7_mask_nonempty: assert property (@(posedge clk) disable iff (rst)
    act_mask != '0);

  a_r10_branch_wins: assert property (@(posedge clk) disable iff (rst)
    (br_valid && adv_valid && eff_tk == act_mask && depth == '0) |=>
      (fetch_pc == $past(br_target)));
endmodule

bind simt_reconv_stack simt_reconv_chk #(
  .NTHREADS(NTHREADS), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .br_valid (br_valid),
  .br_taken (br_taken),
  .br_target(br_target),
  .adv_valid(adv_valid),
  .adv_pc   (adv_pc),
  .fetch_pc (fetch_pc),
  .act_mask (act_mask),
  .overflow (overflow),
  .depth    (lvl_q)
);

// File: tb/test_simt_reconv_stack.sv
module test_simt_reconv_stack;
  localparam int NT = 4;
  localparam int PW = 16;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          br_valid = 1'b0;
  logic [NT-1:0] br_taken = '0;
  logic [PW-1:0] br_target = '0, br_fall = '0, br_reconv = '0;
  logic          adv_valid = 1'b0;
  logic [PW-1:0] adv_pc = '0;
  logic [PW-1:0] fetch_pc;
  logic [NT-1:0] act_mask;
  logic          overflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  simt_reconv_stack #(.NTHREADS(NT), .PC_W(PW), .DEPTH(DP), .RESET_PC(32'h10)) i_simt_reconv_stack (
    .clk(clk), .rst(rst),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .br_fall(br_fall), .br_reconv(br_reconv),
    .adv_valid(adv_valid), .adv_pc(adv_pc),
    .fetch_pc(fetch_pc), .act_mask(act_mask), .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_state(input string req, input logic [PW-1:0] pc, input logic [NT-1:0] m);
    check({req, " pc"}, 32'(fetch_pc), 32'(pc));
    check({req, " mask"}, 32'(act_mask), 32'(m));
  endtask

  // Inputs change at the falling edge, outputs are read at the next falling edge.
  task automatic finish_step();
    @(posedge clk);
    @(negedge clk);
    br_valid  = 1'b0;
    adv_valid = 1'b0;
  endtask

  task automatic do_adv(input logic [PW-1:0] pc);
    adv_valid = 1'b1;
    adv_pc    = pc;
    finish_step();
  endtask

  task automatic do_br(input logic [NT-1:0] tk, input logic [PW-1:0] tgt,
                       input logic [PW-1:0] ft, input logic [PW-1:0] rc);
    br_valid  = 1'b1;
    br_taken  = tk;
    br_target = tgt;
    br_fall   = ft;
    br_reconv = rc;
    finish_step();
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    apply_reset();
    expect_state("R1", 16'h10, 4'b1111);
    check("R1 overflow", 32'(overflow), 0);
  endtask

  task automatic t_advance();
    do_adv(16'h11);
    expect_state("R2", 16'h11, 4'b1111);
    do_adv(16'h0000);
    expect_state("R11", 16'h0000, 4'b1111);
  endtask

  task automatic t_uniform();
    do_br(4'b1111, 16'h50, 16'h12, 16'h60);
    expect_state("R3 all taken", 16'h50, 4'b1111);
    do_br(4'b0000, 16'h70, 16'h51, 16'h60);
    expect_state("R3 none taken", 16'h51, 4'b1111);
  endtask

  task automatic t_diverge();
    do_br(4'b1001, 16'h20, 16'h30, 16'h40);
    expect_state("R4", 16'h20, 4'b1001);
    do_adv(16'h21);
    expect_state("R2 inside path", 16'h21, 4'b1001);
    do_br(4'b0110, 16'h70, 16'h22, 16'h90);
    expect_state("R7", 16'h22, 4'b1001);
    do_br(4'b1111, 16'h40, 16'h23, 16'h90);
    expect_state("R12 R5", 16'h30, 4'b0110);
    do_adv(16'h31);
    expect_state("R5 fall path", 16'h31, 4'b0110);
    do_adv(16'h40);
    expect_state("R6", 16'h40, 4'b1111);
  endtask

  task automatic t_nested();
    do_br(4'b1100, 16'h80, 16'h90, 16'hA0);
    expect_state("R4 outer", 16'h80, 4'b1100);
    do_br(4'b0100, 16'h84, 16'h88, 16'hA0);
    expect_state("R8 inner", 16'h84, 4'b0100);
    check("R8 no overflow", 32'(overflow), 0);
    do_adv(16'hA0);
    expect_state("R8 inner fall", 16'h88, 4'b1000);
    do_adv(16'hA0);
    expect_state("R8 outer fall", 16'h90, 4'b0011);
    do_adv(16'hA0);
    expect_state("R8 rejoin", 16'hA0, 4'b1111);
  endtask

  task automatic t_overflow();
    do_br(4'b0011, 16'hB0, 16'hB4, 16'hC0);
    expect_state("R4 pre", 16'hB0, 4'b0011);
    do_br(4'b0001, 16'hD8, 16'hDC, 16'hD0);
    check("R9 flag", 32'(overflow), 1);
    expect_state("R9 held", 16'hB0, 4'b0011);
    do_adv(16'hB1);
    check("R9 sticky", 32'(overflow), 1);
    check("R9 pc after", 32'(fetch_pc), 32'h00B1);
    apply_reset();
    check("R1 flag cleared", 32'(overflow), 0);
  endtask

  task automatic t_both();
    br_valid  = 1'b1;
    br_taken  = 4'b1111;
    br_target = 16'h55;
    br_fall   = 16'h11;
    br_reconv = 16'h99;
    adv_valid = 1'b1;
    adv_pc    = 16'h77;
    finish_step();
    expect_state("R10", 16'h55, 4'b1111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_advance();
    t_uniform();
    t_diverge();
    t_nested();
    t_overflow();
    t_both();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule